// File: doc/BRIEF.md
# SDRAM Command Sequencer for a Shared Address/Data Bus

This block runs one SDRAM bank group through a 32-bit bus that carries both address and data. For each host access it first puts the full address on the bus and raises an address strobe, so that an external latch can hold the row, bank and column bits. It then issues activate, a column command (read or write), the data beats and a precharge. Auto-refresh commands are inserted when a refresh request is pending. The address splits into row bits at the top, bank-select bits below them and column bits at the bottom. The five lowest address bits leave on a separate burst-address output, which steps once per beat. The A10 line of the memory also has its own output.

Each gap between commands comes from a 4-bit configuration input: precharge-to-activate, activate-to-column, CAS latency, write recovery and refresh recovery. A programmed 0 counts as 1 cycle. Whatever is programmed, an activate and the precharge that closes it are always at least 10 cycles apart. A buffered-command flag stretches every command and the address-strobe phase to two cycles, to suit external buffers on the control lines. The host side takes one request at a time: a valid/ready pair, with a whole burst of write data presented together with the address. Read beats come back through a valid strobe. A one-cycle done pulse marks the end of each access.

Top module: `sdram_mux_seq`

## Requirements
- R1: After reset the command is NOP, address strobe, bus enable, done and read-valid are low, and `req_ready` is high.
- R2: Once a request is accepted, the address strobe is high for H cycles (H = 2 when `buf_cmd` is set, else 1). During those cycles the bus is enabled, carries the accepted address, and the command is NOP. ACT follows in the very next cycle and lasts H cycles.
- R3: A10 carries address bit 20 (row bit 10, with 8 column bits and 2 bank bits) during ACT. It is 0 during READ, WRITE and REF, and 1 during PRE (all banks).
- R4: The command output {ras_n, cas_n, we_n} takes only these values: NOP=111, ACT=011, READ=101, WRITE=100, PRE=010, REF=001.
- R5: The first cycle of READ/WRITE comes exactly e(t_rcd) cycles after the last ACT cycle. Here e(n) = n for n > 0 and e(0) = 1.
- R6: The first read beat is sampled e(t_cl) cycles after the last READ cycle. The 4 beats are sampled on consecutive cycles, with burst_addr = (addr[4:0] + beat) mod 32 during each one. Each beat appears on `rd_data` with `rd_valid` one cycle later. The bus is never driven during a read.
- R7: A write drives beat 0 during the WRITE command cycles and beats 1 to 3 on the following cycles. Beat i is bits [32i+31:32i] of `req_wdata`, with burst_addr = (addr[4:0] + i) mod 32.
- R8: The first PRE cycle is the later of two cycles: 10 cycles after the last ACT cycle, and e(t_wr) cycles after the last write beat (1 cycle after the last read beat).
- R9: After PRE the block returns to idle e(t_rp) cycles after the last PRE cycle. After REF it returns to idle e(t_rfc) cycles after the last REF cycle. No command is issued in between.
- R10: A refresh request arriving while idle issues REF in the next cycle and beats a simultaneous host request. A request arriving during an access is held, and REF is issued one cycle after the post-precharge wait. `req_ready` is high only when idle with no refresh pending.
- R11: With `buf_cmd` set, every command and the address-strobe phase last two cycles.
- R12: `done` pulses for exactly one cycle, the cycle after the final data beat.
- R13: Timing inputs of 0 behave as 1-cycle gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_rp | input | 4 | Precharge-to-activate cycles |
| t_rcd | input | 4 | Activate-to-column cycles |
| t_cl | input | 4 | Column command to first read data |
| t_wr | input | 4 | Last write beat to precharge |
| t_rfc | input | 4 | Refresh recovery cycles |
| buf_cmd | input | 1 | Stretch commands for buffered lines |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address |
| req_wdata | input | 128 | Write burst, beat 0 in low bits |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rd_data | output | 32 | Read beat |
| rd_valid | output | 1 | Read beat valid |
| done | output | 1 | Access finished |
| ref_req | input | 1 | Refresh request pulse |
| ras_n | output | 1 | Command bit 2 |
| cas_n | output | 1 | Command bit 1 |
| we_n | output | 1 | Command bit 0 |
| a10 | output | 1 | Dedicated A10 line |
| addr_strobe | output | 1 | External address latch enable |
| burst_addr | output | 5 | Low address bits, stepping per beat |
| bus_out | output | 32 | Shared bus drive value |
| bus_oe | output | 1 | Shared bus drive enable |
| bus_in | input | 32 | Shared bus sampled value |

## Verification
The bench compares every output against a cycle-exact timeline, computed from the configuration, across randomly chosen timing values, buffered and unbuffered commands, and both directions. This separates the gaps that are exact (activate to column, CAS latency) from the precharge point, which is the later of two limits. The read model drives recognisable data only inside the expected beat window and junk outside it, so a CAS latency that is off by one shows up as wrong data. Directed cases cover all-zero timing, the 10-cycle activate-to-precharge floor winning over write recovery, A10 with row bit 10 set and clear, and refresh requests arriving while idle, together with a host request, and in the middle of an access.

// File: rtl/sdram_mux_seq.sv
module sdram_mux_seq #(
  parameter int DW        = 32,
  parameter int COL_BITS  = 8,
  parameter int BANK_BITS = 2,
  parameter int BURST     = 4,
  parameter int TW        = 4,
  parameter int RAS_MIN   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TW-1:0]         t_rp,
  input  logic [TW-1:0]         t_rcd,
  input  logic [TW-1:0]         t_cl,
  input  logic [TW-1:0]         t_wr,
  input  logic [TW-1:0]         t_rfc,
  input  logic                  buf_cmd,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [DW-1:0]         req_addr,
  input  logic [BURST*DW-1:0]   req_wdata,
  output logic                  req_ready,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_valid,
  output logic                  done,
  input  logic                  ref_req,
  output logic                  ras_n,
  output logic                  cas_n,
  output logic                  we_n,
  output logic                  a10,
  output logic                  addr_strobe,
  output logic [4:0]            burst_addr,
  output logic [DW-1:0]         bus_out,
  output logic                  bus_oe,
  input  logic [DW-1:0]         bus_in
);

  localparam int A10_POS = COL_BITS + BANK_BITS + 10;
  localparam int BTW     = (BURST > 1) ? $clog2(BURST) : 1;
  localparam int RCW     = $clog2(RAS_MIN + 1);
  localparam logic [BTW-1:0] LAST_BEAT = BTW'(BURST - 1);

  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;

  typedef enum logic [3:0] {
    S_IDLE, S_LATCH, S_ACT, S_RD, S_WR, S_WDATA, S_RDATA, S_WAIT, S_PRE, S_REF
  } state_t;

  state_t          state, state_d, tgt, tgt_d, dest;
  logic [TW-1:0]   cnt, cnt_d, gap;
  logic            launch;
  logic            second, ref_pend, we_q;
  logic [RCW-1:0]  ras_cnt;
  logic [BTW-1:0]  beat;
  logic [DW-1:0]   addr_q;
  logic [BURST*DW-1:0] wbuf;
  logic [2:0]      cmd;

  function automatic logic [TW-1:0] eff(input logic [TW-1:0] n);
    return (n == '0) ? TW'(1) : n;
  endfunction

  wire is_cmd_state = state inside {S_LATCH, S_ACT, S_RD, S_WR, S_PRE, S_REF};
  wire pre_go       = (ras_cnt == '0);
  wire go           = (state != S_PRE) || pre_go;
  wire phase_end    = is_cmd_state && go && (!buf_cmd || second);
  wire last_beat    = (beat == LAST_BEAT);
  wire take_ref     = (state == S_IDLE) && (ref_pend || ref_req);
  wire wr_beat      = (state == S_WR) || (state == S_WDATA);

  assign req_ready = (state == S_IDLE) && !ref_pend && !ref_req;

  always_comb begin
    launch  = 1'b0;
    gap     = TW'(1);
    dest    = S_IDLE;
    state_d = state;
    tgt_d   = tgt;
    cnt_d   = cnt;
    case (state)
      S_IDLE:  if (take_ref) state_d = S_REF;
               else if (req_valid) state_d = S_LATCH;
      S_LATCH: if (phase_end) state_d = S_ACT;
      S_ACT:   if (phase_end) begin
                 launch = 1'b1; gap = eff(t_rcd); dest = we_q ? S_WR : S_RD;
               end
      S_RD:    if (phase_end) begin
                 launch = 1'b1; gap = eff(t_cl); dest = S_RDATA;
               end
      S_WR:    if (phase_end) begin
                 if (BURST == 1) begin
                   launch = 1'b1; gap = eff(t_wr); dest = S_PRE;
                 end else begin
                   state_d = S_WDATA;
                 end
               end
      S_WDATA: if (last_beat) begin
                 launch = 1'b1; gap = eff(t_wr); dest = S_PRE;
               end
      S_RDATA: if (last_beat) state_d = S_PRE;
      S_WAIT:  if (cnt == '0) state_d = tgt;
               else cnt_d = cnt - TW'(1);
      S_PRE:   if (phase_end) begin
                 launch = 1'b1; gap = eff(t_rp); dest = S_IDLE;
               end
      S_REF:   if (phase_end) begin
                 launch = 1'b1; gap = eff(t_rfc); dest = S_IDLE;
               end
      default: state_d = S_IDLE;
    endcase
    if (launch) begin
      if (gap == TW'(1)) begin
        state_d = dest;
      end else begin
        state_d = S_WAIT;
        tgt_d   = dest;
        cnt_d   = gap - TW'(2);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tgt      <= S_IDLE;
      cnt      <= '0;
      second   <= 1'b0;
      ref_pend <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wbuf     <= '0;
      ras_cnt  <= '0;
      beat     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= state_d;
      tgt      <= tgt_d;
      cnt      <= cnt_d;
      second   <= is_cmd_state && go && buf_cmd && !second;
      ref_pend <= take_ref ? 1'b0 : (ref_pend || ref_req);
      if (req_valid && req_ready) begin
        addr_q <= req_addr;
        we_q   <= req_write;
        wbuf   <= req_wdata;
      end
      if (state == S_ACT && phase_end)
        ras_cnt <= RCW'(RAS_MIN - 1);
      else if (ras_cnt != '0)
        ras_cnt <= ras_cnt - RCW'(1);
      if (req_valid && req_ready)
        beat <= '0;
      else if ((state == S_WR && phase_end) || state == S_WDATA || state == S_RDATA)
        beat <= last_beat ? '0 : beat + BTW'(1);
      rd_valid <= (state == S_RDATA);
      if (state == S_RDATA) rd_data <= bus_in;
      done <= ((state == S_WDATA || state == S_RDATA) && last_beat) ||
              (BURST == 1 && state == S_WR && phase_end);
    end
  end

  always_comb begin
    cmd = C_NOP;
    a10 = 1'b0;
    case (state)
      S_ACT: begin cmd = C_ACT; a10 = addr_q[A10_POS]; end
      S_RD:  cmd = C_RD;
      S_WR:  cmd = C_WR;
      S_PRE: if (pre_go) begin cmd = C_PRE; a10 = 1'b1; end
      S_REF: cmd = C_REF;
      default: ;
    endcase
  end

  assign {ras_n, cas_n, we_n} = cmd;
  assign addr_strobe = (state == S_LATCH);
  assign bus_oe      = addr_strobe || wr_beat;
  assign bus_out     = addr_strobe ? addr_q : (wr_beat ? wbuf[beat*DW +: DW] : '0);
  assign burst_addr  = addr_q[4:0] + 5'(beat);

endmodule

// File: rtl/sdram_mux_seq_chk.sv
module sdram_mux_seq_chk #(
  parameter int RAS_MIN = 10
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic addr_strobe,
  input logic bus_oe,
  input logic req_ready,
  input logic done
);
  localparam int SW = $clog2(RAS_MIN + 1);
  logic [2:0]    cmd;
  logic [SW-1:0] since_act;

  assign cmd = {ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_act <= SW'(RAS_MIN);
    else if (cmd == 3'b011) since_act <= SW'(1);
    else if (since_act < SW'(RAS_MIN)) since_act <= since_act + SW'(1);
  end

  assert_legal_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd inside {3'b111, 3'b011, 3'b101, 3'b100, 3'b010, 3'b001});

  assert_strobe_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> (bus_oe && cmd == 3'b111));

  assert_strobe_then_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_strobe) |-> (cmd == 3'b011));

  assert_pre_a10_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b010) |-> a10);

  assert_col_ref_a10_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd inside {3'b101, 3'b100, 3'b001}) |-> !a10);

  assert_ras_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b010) |-> (since_act >= SW'(RAS_MIN)));

  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b101) |-> !bus_oe);

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == 3'b111 && !addr_strobe));
endmodule

bind sdram_mux_seq sdram_mux_seq_chk #(.RAS_MIN(RAS_MIN)) i_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .a10(a10), .addr_strobe(addr_strobe), .bus_oe(bus_oe),
  .req_ready(req_ready), .done(done)
);

// File: tb/test_sdram_mux_seq.sv
module test_sdram_mux_seq;
  localparam int BURST = 4;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] t_rp = 0, t_rcd = 0, t_cl = 0, t_wr = 0, t_rfc = 0;
  logic buf_cmd = 0, req_valid = 0, req_write = 0, ref_req = 0;
  logic [31:0] req_addr = 0, bus_in = 0;
  logic [BURST*32-1:0] req_wdata = 0;
  logic req_ready, rd_valid, done, ras_n, cas_n, we_n, a10, addr_strobe, bus_oe;
  logic [31:0] rd_data, bus_out;
  logic [4:0] burst_addr;
  int checks = 0, fails = 0;
  string xtag = "";

  always #10 clk = ~clk;

  sdram_mux_seq i_sdram_mux_seq (
    .clk(clk), .rst_n(rst_n), .t_rp(t_rp), .t_rcd(t_rcd), .t_cl(t_cl),
    .t_wr(t_wr), .t_rfc(t_rfc), .buf_cmd(buf_cmd), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
    .addr_strobe(addr_strobe), .burst_addr(burst_addr), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in)
  );

  function automatic int eff(input logic [3:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a, input int i);
    logic [31:0] w;
    w = {a[31:5], 5'(a[4:0] + 5'(i))};
    return (w * 32'h9E37_79B1) ^ 32'h3C3C_5A5A;
  endfunction

  task automatic chk(input string tag, input int cyc, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, xtag, cyc, act, exp);
    end
  endtask

  task automatic do_access(input bit we, input logic [31:0] addr,
                           input logic [BURST*32-1:0] wd, input bit inj);
    int h, al, rwf, rwl, l, d0, pf, pl, ff, fl, e, ref_at, bi;
    logic [2:0] ec;
    h = buf_cmd ? 2 : 1;
    al = 2 * h;
    rwf = al + eff(t_rcd);
    rwl = rwf + h - 1;
    if (we) begin
      d0 = -100; l = rwl + BURST - 1; pf = mx(l + eff(t_wr), al + 10);
    end else begin
      d0 = rwl + eff(t_cl); l = d0 + BURST - 1; pf = mx(l + 1, al + 10);
    end
    pl = pf + h - 1;
    ref_at = inj ? 1 + int'($urandom % al) : -1;
    if (inj) begin
      ff = pl + eff(t_rp) + 1; fl = ff + h - 1; e = fl + eff(t_rfc);
    end else begin
      ff = -100; fl = -100; e = pl + eff(t_rp);
    end
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = addr; req_wdata = wd; #1;
    chk("R10 ready idle", 0, 32'(req_ready), 1);
    for (int k = 1; k <= e; k++) begin
      @(negedge clk);
      req_valid = 0;
      ref_req = (k == ref_at);
      bus_in = (!we && k >= d0 && k <= l) ? mem_word(addr, k - d0) : (32'hBAD0_0000 | 32'(k));
      #1;
      if (k > h && k <= al) ec = C_ACT;
      else if (k >= rwf && k <= rwl) ec = we ? C_WR : C_RD;
      else if (k >= pf && k <= pl) ec = C_PRE;
      else if (k >= ff && k <= fl) ec = C_REF;
      else ec = C_NOP;
      if (ec == C_ACT) chk("R4 R2 act", k, 32'({ras_n, cas_n, we_n}), 32'(ec));
      else if (ec == C_RD || ec == C_WR) chk("R4 R5 column", k, 32'({ras_n, cas_n, we_n}), 32'(ec));
      else if (ec == C_PRE) chk("R4 R8 precharge", k, 32'({ras_n, cas_n, we_n}), 32'(ec));
      else if (ec == C_REF) chk("R4 R10 refresh", k, 32'({ras_n, cas_n, we_n}), 32'(ec));
      else chk("R4 R9 nop", k, 32'({ras_n, cas_n, we_n}), 32'(ec));
      if (ec == C_ACT) chk("R3 a10 act", k, 32'(a10), 32'(addr[20]));
      else if (ec == C_PRE) chk("R3 a10 pre", k, 32'(a10), 1);
      else if (ec != C_NOP) chk("R3 a10 zero", k, 32'(a10), 0);
      chk("R2 R11 strobe", k, 32'(addr_strobe), 32'(k <= h));
      chk("R2 R7 bus_oe", k, 32'(bus_oe), 32'(k <= h || (we && k >= rwf && k <= l)));
      if (k <= h) chk("R2 address", k, bus_out, addr);
      if (we && k >= rwf && k <= l) begin
        bi = (k <= rwl) ? 0 : k - rwl;
        chk("R7 wdata", k, bus_out, wd[bi*32 +: 32]);
        chk("R7 burst_addr", k, 32'(burst_addr), 32'(5'(addr[4:0] + 5'(bi))));
      end
      if (!we && k >= d0 && k <= l)
        chk("R6 burst_addr", k, 32'(burst_addr), 32'(5'(addr[4:0] + 5'(k - d0))));
      chk("R6 rd_valid", k, 32'(rd_valid), 32'(!we && k >= d0 + 1 && k <= l + 1));
      if (!we && k >= d0 + 1 && k <= l + 1)
        chk("R6 rd_data", k, rd_data, mem_word(addr, k - d0 - 1));
      chk("R12 done", k, 32'(done), 32'(k == l + 1));
      chk("R10 ready", k, 32'(req_ready), 32'(k == e));
    end
    ref_req = 0;
  endtask

  task automatic idle_ref(input bit with_req);
    int h, e;
    h = buf_cmd ? 2 : 1;
    e = h + eff(t_rfc);
    @(negedge clk);
    ref_req = 1; req_valid = with_req; req_addr = 32'h1234_5678; #1;
    chk("R10 ready blocked", 0, 32'(req_ready), 0);
    for (int k = 1; k <= e; k++) begin
      @(negedge clk);
      ref_req = 0;
      if (k == e) req_valid = 0;
      #1;
      chk("R10 R9 idle refresh", k, 32'({ras_n, cas_n, we_n}), 32'((k <= h) ? C_REF : C_NOP));
      if (k <= h) chk("R3 a10 ref", k, 32'(a10), 0);
      chk("R10 no strobe", k, 32'(addr_strobe), 0);
      chk("R10 ready", k, 32'(req_ready), 32'(k == e));
    end
  endtask

  task automatic set_cfg(input int rp, input int rcd, input int cl, input int wr,
                         input int rfc, input bit b);
    @(negedge clk);
    t_rp = 4'(rp); t_rcd = 4'(rcd); t_cl = 4'(cl); t_wr = 4'(wr); t_rfc = 4'(rfc);
    buf_cmd = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset cmd", 0, 32'({ras_n, cas_n, we_n}), 32'(C_NOP));
    chk("R1 reset strobe", 0, 32'(addr_strobe), 0);
    chk("R1 reset oe", 0, 32'(bus_oe), 0);
    chk("R1 reset done", 0, 32'(done), 0);
    chk("R1 reset rd_valid", 0, 32'(rd_valid), 0);
    chk("R1 reset ready", 0, 32'(req_ready), 1);
    @(negedge clk); rst_n = 1;

    xtag = "R13";
    set_cfg(0, 0, 0, 0, 0, 0);
    do_access(1, 32'h0010_0003, {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 0);
    do_access(0, 32'h0000_001E, '0, 0);
    set_cfg(0, 0, 0, 0, 0, 1);
    xtag = "R13 R11";
    do_access(0, 32'hFFF0_0011, '0, 0);
    idle_ref(0);

    xtag = "max";
    set_cfg(15, 15, 15, 15, 15, 0);
    do_access(0, 32'h0010_0000, '0, 0);
    do_access(1, 32'hABCF_FFFF, {4{32'h5A5A_A5A5}}, 1);

    xtag = "ras floor";
    set_cfg(2, 1, 2, 1, 3, 0);
    do_access(1, 32'h8765_4321, {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0BAD_F00D, 32'h1234_5678}, 0);
    idle_ref(1);
    do_access(0, 32'h0012_3440, '0, 1);

    for (int i = 0; i < 60; i++) begin
      set_cfg(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
              int'($urandom % 16), int'($urandom % 16), 1'($urandom % 2));
      xtag = buf_cmd ? "R11 rand" : "rand";
      if ($urandom % 8 == 0) idle_ref(1'($urandom % 2));
      do_access(1'($urandom % 2), $urandom,
                {$urandom, $urandom, $urandom, $urandom}, ($urandom % 3) == 0);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule